// File: doc/BRIEF.md
# Single-Word Interrupt Controller with Tick Counter

This block gathers three interrupt sources for a small 32-bit processor: a serial port, a periodic timer tick that it makes itself, and an audio source formed from several channel request lines. Every source pulse is latched into a pending flag. The flags are readable in the low bits of one register word. The top 24 bits of the same word hold a free-running count of timer ticks since reset. The count is driven by an internal prescaler that divides the system clock.

Delivery of interrupts is gated by one global enable, which software sets by writing the register with bit 7 high. The enable is one-shot. On the cycle the request line to the processor is high, the enable is cleared. The handler therefore has to write the register again to accept the next interrupt. That re-arming write also clears the pending flags. A source pulse that arrives in the same cycle as the re-arming write is still kept.

Top module: `irq_hub`

## Requirements
- R1: While reset is held and right after it, the read word is all zeros and the processor request line is low.
- R2: The internal tick fires once every TICK_DIV clock cycles. After n rising edges since reset release, the tick count equals floor(n / TICK_DIV).
- R3: Read bits 31..8 hold an unsigned 24-bit tick count. It rises by exactly one per tick, wraps modulo 2^24, and holds between ticks.
- R4: A one-cycle source pulse sets its pending flag: bit 0 for the serial port, bit 1 for the timer tick, bit 2 for audio. The flag stays set until a write with bit 7 set. A write with bit 7 clear does not change the flags.
- R5: The internal timer tick sets pending bit 1 in the same cycle that the count advances.
- R6: A pulse on any one of the audio channel request lines sets pending bit 2.
- R7: A write with bit 7 set turns the global enable on. A write with bit 7 clear turns it off. While the enable is off, pending flags never raise the request line.
- R8: The request line is high exactly when the enable is on and at least one pending flag is set. On the edge that ends a high request cycle, the enable clears itself, unless a write occurs in that cycle. The request line is therefore a single-cycle pulse.
- R9: When a source pulse arrives in the same cycle as a re-arming write, that source's flag is set after the write, not cleared.
- R10: Read bits 7..3 always read as zero. Write data bits other than bit 7 have no effect on the flags or on the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data; only bit 7 is used |
| rd_data | output | 32 | Register read word: tick count in bits 31..8, pending flags in bits 2..0 |
| uart_req | input | 1 | Serial-port interrupt pulse |
| audio_req | input | AUD_CH | Audio channel interrupt pulses, combined by OR |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
Every cycle, the assertions check the following: the count steps by one on a tick and holds otherwise; ticks never come back to back; pending flags hold unless cleared; a pulse that meets a clearing write still sets its flag; a write loads the enable; and the request line never stays high for two cycles without a write. Other behaviours need the bench's directed scenarios. These are the absolute tick period measured against the reset release, the mapping of each source to its bit, that a disabling write leaves the flags alone, and the zero bits of the read word.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int DATA_W    = 32;
  localparam int CNT_W     = 24;
  localparam int NUM_SRC   = 3;
  localparam int SRC_UART  = 0;
  localparam int SRC_TICK  = 1;
  localparam int SRC_AUDIO = 2;
  localparam int ARM_BIT   = 7;
  localparam int GAP_W     = DATA_W - CNT_W - NUM_SRC;

  // next tick count, wrapping at 2^CNT_W
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] cur);
    return cur + CNT_W'(1);
  endfunction

  // assemble the register read word
  function automatic logic [DATA_W-1:0] pack_word(input logic [CNT_W-1:0] cnt,
                                                  input logic [NUM_SRC-1:0] pend);
    return {cnt, {GAP_W{1'b0}}, pend};
  endfunction
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_pulse
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick_pulse = (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)          pre_q <= '0;
    else if (tick_pulse) pre_q <= '0;
    else                 pre_q <= pre_q + PW'(1);
  end

  generate
    if (TICK_DIV > 1) begin : g_gap
      // R2: ticks are separated by idle cycles when dividing
      p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> !tick_pulse);
    end
  endgenerate
endmodule

// File: rtl/irq_tick_count.sv
module irq_tick_count
  import irq_hub_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_pulse,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (tick_pulse) cnt_q <= cnt_step(cnt_q);
  end

  assign count = cnt_q;

  // R3: one step per tick, modulo 2^24
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pulse |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R3: no movement between ticks
  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_pulse |=> $stable(cnt_q));
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_hub_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic               clr_all,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] pend_q;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rst_n)          pend_q[i] <= 1'b0;
        else if (src_set[i]) pend_q[i] <= 1'b1;
        else if (clr_all)    pend_q[i] <= 1'b0;
      end

      // R4: a set flag survives every cycle without a clearing write
      p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[i] && !clr_all) |=> pend_q[i]);
      // R9: a pulse meeting a clearing write is not lost
      p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set[i] && clr_all) |=> pend_q[i]);
    end
  endgenerate

  assign pend = pend_q;
endmodule

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_arm,
  input  logic any_pend,
  output logic cpu_irq
);
  logic en_q;
  logic fire;

  assign fire    = en_q && any_pend;
  assign cpu_irq = fire;

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (wr_en) en_q <= wr_arm;
    else if (fire)  en_q <= 1'b0;
  end

  // R7: a write loads the enable from bit 7
  p_en_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_q == $past(wr_arm)));
  // R8: delivery consumes the enable, so the request is one cycle long
  p_oneshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr_en) |=> (!en_q && !cpu_irq));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int TICK_DIV = 1000,
  parameter int AUD_CH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              uart_req,
  input  logic [AUD_CH-1:0] audio_req,
  output logic              cpu_irq
);
  logic               tick_pulse;
  logic [CNT_W-1:0]   tick_cnt;
  logic [NUM_SRC-1:0] src_set;
  logic [NUM_SRC-1:0] pend;
  logic               arm_write;
  logic               unused_wr;

  assign arm_write = wr_en && wr_data[ARM_BIT];
  assign unused_wr = ^wr_data;

  always_comb begin
    src_set            = '0;
    src_set[SRC_UART]  = uart_req;
    src_set[SRC_TICK]  = tick_pulse;
    src_set[SRC_AUDIO] = |audio_req;
  end

  irq_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_pulse(tick_pulse)
  );

  irq_tick_count u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_pulse(tick_pulse), .count(tick_cnt)
  );

  irq_pend_bank u_pend (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .clr_all(arm_write), .pend(pend)
  );

  irq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_arm(wr_data[ARM_BIT]),
    .any_pend(|pend), .cpu_irq(cpu_irq)
  );

  assign rd_data = pack_word(tick_cnt, pend);

  // R5: the tick flag is pending right after every tick
  p_tick_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pulse |=> rd_data[SRC_TICK]);
endmodule

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
  localparam int CLK_P = 10;
  localparam int DIV   = 1000;
  localparam int NCH   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [31:0]     wr_data = '0;
  logic [31:0]     rd_data;
  logic            uart_req = 1'b0;
  logic [NCH-1:0]  audio_req = '0;
  logic            cpu_irq;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  irq_hub #(.TICK_DIV(DIV), .AUD_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .uart_req(uart_req), .audio_req(audio_req),
    .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_uart();
    @(negedge clk); uart_req = 1'b1;
    @(negedge clk); uart_req = 1'b0;
  endtask

  task automatic pulse_audio(input int ch);
    @(negedge clk); audio_req[ch] = 1'b1;
    @(negedge clk); audio_req = '0;
  endtask

  task automatic chk_count(input string tag);
    chk(tag, {8'h0, rd_data[31:8]}, 32'(edges / DIV));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 word in reset", rd_data, 32'h0);
    chk("R1 irq in reset", {31'h0, cpu_irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 word after release", rd_data, 32'h0);
    chk("R1 irq after release", {31'h0, cpu_irq}, 32'h0);
  endtask

  task automatic t_latch_disabled();
    pulse_uart();
    chk("R4 uart flag set", {29'h0, rd_data[2:0]}, 32'h1);
    chk("R7 no irq while disabled", {31'h0, cpu_irq}, 32'h0);
    wr(32'h0000_0000);
    chk("R4 disable write keeps flag", {29'h0, rd_data[2:0]}, 32'h1);
    wr(32'h0000_0080);
    chk("R4 arm write clears flags", {29'h0, rd_data[2:0]}, 32'h0);
    chk("R7 armed without pending", {31'h0, cpu_irq}, 32'h0);
    chk_count("R3 count before first tick");
  endtask

  task automatic t_deliver_oneshot();
    pulse_uart();
    chk("R8 irq on pending", {31'h0, cpu_irq}, 32'h1);
    chk("R4 uart bit 0", {29'h0, rd_data[2:0]}, 32'h1);
    @(negedge clk);
    chk("R8 irq one cycle", {31'h0, cpu_irq}, 32'h0);
    chk("R4 flag outlives delivery", {29'h0, rd_data[2:0]}, 32'h1);
    pulse_audio(0);
    chk("R7 consumed enable blocks", {31'h0, cpu_irq}, 32'h0);
    chk("R6 audio bit 2", {29'h0, rd_data[2:0]}, 32'h5);
  endtask

  task automatic t_disable_audio();
    wr(32'h0000_0080);
    chk("R4 rearm clears", {29'h0, rd_data[2:0]}, 32'h0);
    wr(32'h0000_0000);
    pulse_audio(3);
    chk("R6 channel 3 sets bit 2", {29'h0, rd_data[2:0]}, 32'h4);
    chk("R7 disable write blocks", {31'h0, cpu_irq}, 32'h0);
  endtask

  task automatic t_audio_enabled();
    wr(32'h0000_0080);
    pulse_audio(1);
    chk("R6 channel 1 delivers", {31'h0, cpu_irq}, 32'h1);
    chk("R6 channel 1 flag", {29'h0, rd_data[2:0]}, 32'h4);
  endtask

  task automatic t_same_cycle();
    @(negedge clk); wr_en = 1'b1; wr_data = 32'h80; uart_req = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_data = '0; uart_req = 1'b0;
    chk("R9 pulse survives rearm", {29'h0, rd_data[2:0]}, 32'h1);
    chk("R9 irq after rearm", {31'h0, cpu_irq}, 32'h1);
  endtask

  task automatic t_ignored_bits();
    wr(32'hFFFF_FF7F);
    chk("R10 low byte after 0x..7F", {24'h0, rd_data[7:0]}, 32'h01);
    chk("R10 no arm without bit 7", {31'h0, cpu_irq}, 32'h0);
    wr(32'h0000_00FF);
    chk("R10 low byte after 0xFF", {24'h0, rd_data[7:0]}, 32'h00);
    pulse_uart();
    chk("R7 0xFF arms", {31'h0, cpu_irq}, 32'h1);
    chk_count("R3 count still zero");
  endtask

  task automatic t_tick();
    wr(32'h0000_0080);
    while (edges < DIV - 1) @(negedge clk);
    chk("R2 no tick before period", {8'h0, rd_data[31:8]}, 32'h0);
    chk("R5 tick flag clear before", {31'h0, rd_data[1]}, 32'h0);
    @(negedge clk);
    chk("R2 first tick at period", {8'h0, rd_data[31:8]}, 32'h1);
    chk("R5 tick flag set", {31'h0, rd_data[1]}, 32'h1);
    chk("R5 tick delivers", {31'h0, cpu_irq}, 32'h1);
    while (edges < 2 * DIV - 1) @(negedge clk);
    chk("R3 count holds between ticks", {8'h0, rd_data[31:8]}, 32'h1);
    @(negedge clk);
    chk("R3 count steps by one", {8'h0, rd_data[31:8]}, 32'h2);
    chk_count("R2 count matches period");
  endtask

  initial begin
    t_reset();
    t_latch_disabled();
    t_deliver_oneshot();
    t_disable_audio();
    t_audio_enabled();
    t_same_cycle();
    t_ignored_bits();
    t_tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule